// File: doc/BRIEF.md
# Page ECC Chunk Sequencing Controller

This controller drives a page-level error-correction engine across a page split into N equal chunks. Each chunk holds user data, then spare metadata, then parity. A program request walks the chunks in order while the engine computes parity. A read request walks them in order while the engine checks and repairs them. The controller grades every decoded chunk and folds the grades into one page status word. That word reports the worst correction effort and flags any chunk that could not be repaired.

The engine's arithmetic sits outside this block. It answers each chunk through a small result interface: a completion strobe, an error count and an unrecoverable flag. Correction can be switched off, so reads stream through untouched and an external scheme recovers the data. A continuous mode reads page after page with no gap for as long as the device stays selected. The correctable limit depends on the interface mode.

Top module: `page_ecc_seq`

## Requirements
- R1: When idle, `prog_start_i` starts an encode page. `enc_active_o` is high from the next cycle. `chunk_idx_o` starts at 0 and advances by one on each `chunk_done_i`. The engine's results are ignored.
- R2: When idle, `read_start_i` with `decode_en_i` high starts a decode page. `dec_active_o` is high and the chunks are walked as in R1.
- R3: Each decoded chunk is graded against a limit. The limit is LIM_SER when `par_mode_i` was low at page start, and LIM_PAR when it was high. The grades are: 2'b00 for zero errors, 2'b01 for a count below the limit, and 2'b10 for a count equal to the limit.
- R4: A chunk is graded 2'b11 if it reports `uncorr_i`, or if its count is above the limit.
- R5: `status_o` is the highest grade seen in the current page. It clears to 2'b00 when a page starts, and holds after the page until the next start. It stays 2'b00 through an encode page.
- R6: A read with `decode_en_i` low takes the bypass path. There is no decode strobe, and the engine's results are ignored. The index advances once per cycle, the status stays 2'b00, and `done_o` follows N cycles after the start cycle.
- R7: `meta_incl_o` equals `meta_prot_i` as sampled at page start. It holds for the whole page, whatever `meta_prot_i` does after the start.
- R8: A decode read started with `cont_read_i` high runs on the continuous path, with `cr_active_o` high. After each done cycle, if `select_i` is high, the next page starts at once with index 0 and a cleared status. Otherwise the block returns to idle.
- R9: Start requests are ignored while `busy_o` is high. If both starts arrive in the same idle cycle, the program request wins.
- R10: `done_o` is a single-cycle pulse, in the cycle after the last chunk completes. `chunk_idx_o` is 0 whenever `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prog_start_i | input | 1 | Start an encode page |
| read_start_i | input | 1 | Start a read page |
| decode_en_i | input | 1 | Internal correction enabled |
| cont_read_i | input | 1 | Request the continuous read path |
| select_i | input | 1 | Device selected; low ends continuous read at the page boundary |
| meta_prot_i | input | 1 | Include metadata in parity |
| par_mode_i | input | 1 | Parallel interface mode (selects LIM_PAR) |
| chunk_done_i | input | 1 | Engine finished the current chunk |
| err_cnt_i | input | CNT_W | Error count of the finished chunk |
| uncorr_i | input | 1 | Finished chunk is unrecoverable |
| enc_active_o | output | 1 | Encode page in progress |
| dec_active_o | output | 1 | Decode page in progress |
| cr_active_o | output | 1 | Continuous read path active |
| busy_o | output | 1 | Page operation in progress |
| done_o | output | 1 | Page complete pulse |
| chunk_idx_o | output | IDX_W | Current chunk index |
| meta_incl_o | output | 1 | Metadata included in parity for this page |
| status_o | output | 2 | Worst chunk grade of the page |

## Verification
A start request seen at one clock edge raises the activity strobe and shows index 0 after that edge. A completion strobe moves the index and folds the grade into the status at the same edge it is sampled. The done cycle, with its final status, follows the edge that takes the last completion. In bypass, the done cycle comes N edges after the start edge. The bench drives and samples on falling edges. Its driver pushes each page's expected status into a queue. Its monitor pops and compares that status only in a cycle where done is high. Every index, strobe and status check sits at the falling edge that follows the edge counted for it.

// File: rtl/page_ecc_pkg.sv
package page_ecc_pkg;
  typedef enum logic [1:0] {
    GR_CLEAN = 2'b00,
    GR_FIXED = 2'b01,
    GR_LIMIT = 2'b10,
    GR_FAIL  = 2'b11
  } grade_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ENC,
    S_DEC,
    S_CRD,
    S_BYP,
    S_FIN
  } seq_state_e;
endpackage

// File: rtl/ecc_chunk_grade.sv
module ecc_chunk_grade #(
  parameter int CNT_W   = 4,
  parameter int LIM_SER = 8,
  parameter int LIM_PAR = 4
) (
  input  logic             par_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             uncorr_i,
  output logic [1:0]       grade_o
);
  import page_ecc_pkg::*;

  localparam logic [CNT_W-1:0] LimS = CNT_W'(LIM_SER);
  localparam logic [CNT_W-1:0] LimP = CNT_W'(LIM_PAR);

  logic [CNT_W-1:0] lim;
  assign lim = par_i ? LimP : LimS;

  always_comb begin
    if (uncorr_i || (cnt_i > lim))        grade_o = GR_FAIL;
    else if (cnt_i == lim && cnt_i != '0) grade_o = GR_LIMIT;
    else if (cnt_i != '0)                 grade_o = GR_FIXED;
    else                                  grade_o = GR_CLEAN;
  end
endmodule

// File: rtl/ecc_status_merge.sv
module ecc_status_merge (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       upd_i,
  input  logic [1:0] grade_i,
  output logic [1:0] status_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          status_o <= 2'b00;
    else if (clr_i)                       status_o <= 2'b00;
    else if (upd_i && grade_i > status_o) status_o <= grade_i;
  end
endmodule

// File: rtl/ecc_seq_fsm.sv
module ecc_seq_fsm #(
  parameter int N_CHUNK = 8,
  localparam int IDX_W  = (N_CHUNK > 1) ? $clog2(N_CHUNK) : 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           prog_start_i,
  input  logic                           read_start_i,
  input  logic                           decode_en_i,
  input  logic                           cont_read_i,
  input  logic                           select_i,
  input  logic                           chunk_done_i,
  output page_ecc_pkg::seq_state_e       state_o,
  output logic [IDX_W-1:0]               idx_o,
  output logic                           page_start_o,
  output logic                           upd_o
);
  import page_ecc_pkg::*;

  localparam logic [IDX_W-1:0] LastIdx = IDX_W'(N_CHUNK - 1);

  seq_state_e state_q, state_d;
  logic [IDX_W-1:0] idx_q;
  logic cont_q, cont_d;
  logic step, last;

  assign step = ((state_q == S_ENC || state_q == S_DEC || state_q == S_CRD) && chunk_done_i)
              || (state_q == S_BYP);
  assign last = step && (idx_q == LastIdx);

  always_comb begin
    state_d      = state_q;
    cont_d       = cont_q;
    page_start_o = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (prog_start_i) begin
          state_d      = S_ENC;
          cont_d       = 1'b0;
          page_start_o = 1'b1;
        end else if (read_start_i) begin
          page_start_o = 1'b1;
          cont_d       = decode_en_i && cont_read_i;
          if (!decode_en_i)     state_d = S_BYP;
          else if (cont_read_i) state_d = S_CRD;
          else                  state_d = S_DEC;
        end
      end
      S_ENC, S_DEC, S_CRD, S_BYP: if (last) state_d = S_FIN;
      S_FIN: begin
        if (cont_q && select_i) begin
          state_d      = S_CRD;
          page_start_o = 1'b1;
        end else begin
          state_d = S_IDLE;
          cont_d  = 1'b0;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cont_q  <= 1'b0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      cont_q  <= cont_d;
      if (page_start_o || last) idx_q <= '0;
      else if (step)            idx_q <= idx_q + 1'b1;
    end
  end

  assign state_o = state_q;
  assign idx_o   = idx_q;
  assign upd_o   = (state_q == S_DEC || state_q == S_CRD) && chunk_done_i;
endmodule

// File: rtl/page_ecc_seq.sv
module page_ecc_seq #(
  parameter int N_CHUNK = 8,
  parameter int CNT_W   = 4,
  parameter int LIM_SER = 8,
  parameter int LIM_PAR = 4,
  localparam int IDX_W  = (N_CHUNK > 1) ? $clog2(N_CHUNK) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prog_start_i,
  input  logic             read_start_i,
  input  logic             decode_en_i,
  input  logic             cont_read_i,
  input  logic             select_i,
  input  logic             meta_prot_i,
  input  logic             par_mode_i,
  input  logic             chunk_done_i,
  input  logic [CNT_W-1:0] err_cnt_i,
  input  logic             uncorr_i,
  output logic             enc_active_o,
  output logic             dec_active_o,
  output logic             cr_active_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [IDX_W-1:0] chunk_idx_o,
  output logic             meta_incl_o,
  output logic [1:0]       status_o
);
  import page_ecc_pkg::*;

  seq_state_e state;
  logic page_start, upd, par_q, meta_q;
  logic [1:0] grade;

  ecc_seq_fsm #(.N_CHUNK(N_CHUNK)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .prog_start_i (prog_start_i),
    .read_start_i (read_start_i),
    .decode_en_i  (decode_en_i),
    .cont_read_i  (cont_read_i),
    .select_i     (select_i),
    .chunk_done_i (chunk_done_i),
    .state_o      (state),
    .idx_o        (chunk_idx_o),
    .page_start_o (page_start),
    .upd_o        (upd)
  );

  // page configuration is frozen at each page start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_q  <= 1'b0;
      meta_q <= 1'b0;
    end else if (page_start) begin
      par_q  <= par_mode_i;
      meta_q <= meta_prot_i;
    end
  end

  ecc_chunk_grade #(.CNT_W(CNT_W), .LIM_SER(LIM_SER), .LIM_PAR(LIM_PAR)) u_grade (
    .par_i    (par_q),
    .cnt_i    (err_cnt_i),
    .uncorr_i (uncorr_i),
    .grade_o  (grade)
  );

  ecc_status_merge u_merge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (page_start),
    .upd_i    (upd),
    .grade_i  (grade),
    .status_o (status_o)
  );

  assign enc_active_o = (state == S_ENC);
  assign dec_active_o = (state == S_DEC) || (state == S_CRD);
  assign cr_active_o  = (state == S_CRD);
  assign busy_o       = (state != S_IDLE);
  assign done_o       = (state == S_FIN);
  assign meta_incl_o  = meta_q;
endmodule

// File: rtl/page_ecc_seq_chk.sv
module page_ecc_seq_chk #(
  parameter int N_CHUNK = 8,
  parameter int IDX_W   = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             chunk_done_i,
  input logic             uncorr_i,
  input logic             enc_active_o,
  input logic             dec_active_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [IDX_W-1:0] chunk_idx_o,
  input logic [1:0]       status_o
);
  a_r1_r2_one_activity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({enc_active_o, dec_active_o, done_o}));

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_idx_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> chunk_idx_o == '0);

  a_r1_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(chunk_idx_o) < N_CHUNK);

  a_r4_fail_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_active_o && chunk_done_i && uncorr_i) |=> status_o == 2'b11);

  a_r5_status_monotone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_active_o && $past(dec_active_o)) |-> status_o >= $past(status_o));

  a_r5_encode_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_active_o |-> status_o == 2'b00);

  a_r6_bypass_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !enc_active_o && !dec_active_o && !done_o) |-> status_o == 2'b00);
endmodule

bind page_ecc_seq page_ecc_seq_chk #(.N_CHUNK(N_CHUNK), .IDX_W(IDX_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .chunk_done_i (chunk_done_i),
  .uncorr_i     (uncorr_i),
  .enc_active_o (enc_active_o),
  .dec_active_o (dec_active_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .chunk_idx_o  (chunk_idx_o),
  .status_o     (status_o)
);

// File: tb/page_ecc_seq_tb.sv
module page_ecc_seq_tb;
  localparam int N = 8;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_start = 0, read_start = 0, dec_en = 1, cont = 0, sel = 1;
  logic meta = 0, par = 0, cdone = 0, unc = 0;
  logic [CW-1:0] ecnt = '0;
  logic enc_a, dec_a, cr_a, busy, done;
  logic [2:0] idx;
  logic meta_o;
  logic [1:0] status;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;
  logic [1:0] expq[$];
  int ccnt[N];
  bit cunc[N];

  always #5 clk = ~clk;

  page_ecc_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .prog_start_i(prog_start), .read_start_i(read_start),
    .decode_en_i(dec_en), .cont_read_i(cont), .select_i(sel), .meta_prot_i(meta),
    .par_mode_i(par), .chunk_done_i(cdone), .err_cnt_i(ecnt), .uncorr_i(unc),
    .enc_active_o(enc_a), .dec_active_o(dec_a), .cr_active_o(cr_a), .busy_o(busy),
    .done_o(done), .chunk_idx_o(idx), .meta_incl_o(meta_o), .status_o(status)
  );

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d t=%0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [1:0] grade(int c, bit u, bit p);
    int lim = p ? 4 : 8;
    if (u || c > lim) return 2'b11;
    if (c == lim) return 2'b10;
    if (c != 0) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [1:0] page_exp(bit p);
    logic [1:0] m = 2'b00;
    for (int k = 0; k < N; k++) if (grade(ccnt[k], cunc[k], p) > m) m = grade(ccnt[k], cunc[k], p);
    return m;
  endfunction

  task automatic set_chunks(int c0, int c1, int c2, int c3, int c4, int c5, int c6, int c7, int ubad);
    ccnt = '{c0, c1, c2, c3, c4, c5, c6, c7};
    for (int k = 0; k < N; k++) cunc[k] = (k == ubad);
  endtask

  // walk all chunks; returns at the falling edge of the done cycle
  task automatic run_chunks(bit gap);
    for (int k = 0; k < N; k++) begin
      if (gap && (k % 2 == 1)) @(negedge clk);
      chk("R1/R2 idx", int'(idx), k);
      cdone = 1; ecnt = CW'(ccnt[k]); unc = cunc[k];
      @(negedge clk);
      cdone = 0; ecnt = '0; unc = 0;
    end
  endtask

  task automatic start(bit is_prog);
    if (is_prog) prog_start = 1; else read_start = 1;
    @(negedge clk);
    prog_start = 0; read_start = 0;
  endtask

  // monitor: scoreboard compare on done
  always @(negedge clk) begin
    if (rst_n && done) begin
      checks++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R5 unexpected done got=%0d exp=none", status);
      end else begin
        logic [1:0] e;
        e = expq.pop_front();
        if (status != e) begin
          fails++;
          $display("FAIL R5 page status got=%0d exp=%0d t=%0t", status, e, $time);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      fails++;
      $display("FAIL watchdog got=%0d exp=<50000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset busy", int'(busy), 0);
    chk("R10 reset idx", int'(idx), 0);
    chk("R5 reset status", int'(status), 0);
    rst_n = 1;
    @(negedge clk);

    // R1 encode, results ignored, meta latched (R7)
    set_chunks(9, 9, 9, 9, 9, 9, 9, 9, 3);
    expq.push_back(2'b00);
    meta = 1;
    start(1);
    chk("R1 enc_active", int'(enc_a), 1);
    chk("R1 dec_active", int'(dec_a), 0);
    meta = 0;
    run_chunks(1);
    chk("R10 done", int'(done), 1);
    chk("R7 meta held", int'(meta_o), 1);
    @(negedge clk);
    chk("R10 idle idx", int'(idx), 0);
    chk("R10 done pulse", int'(done), 0);
    chk("R1 back idle", int'(busy), 0);

    // R2/R3 serial decode with at-limit chunk, R9 start ignored when busy
    set_chunks(0, 1, 3, 8, 2, 0, 0, 1, -1);
    expq.push_back(page_exp(0));
    start(0);
    chk("R2 dec_active", int'(dec_a), 1);
    chk("R7 meta off", int'(meta_o), 0);
    prog_start = 1;
    @(negedge clk);
    prog_start = 0;
    chk("R9 busy start ignored", int'(enc_a), 0);
    chk("R9 decode continues", int'(dec_a), 1);
    run_chunks(0);
    @(negedge clk);
    chk("R5 status held after page", int'(status), 2);

    // R3 parallel: 4 is at the limit
    set_chunks(1, 0, 4, 0, 2, 0, 3, 0, -1);
    par = 1;
    expq.push_back(page_exp(1));
    start(0);
    chk("R5 cleared at start", int'(status), 0);
    run_chunks(1);
    @(negedge clk);
    chk("R3 parallel limit", int'(status), 2);

    // R3 same counts, serial: below limit
    par = 0;
    expq.push_back(page_exp(0));
    start(0);
    run_chunks(0);
    @(negedge clk);
    chk("R3 serial below limit", int'(status), 1);

    // R4 flagged chunk, then count above limit
    set_chunks(1, 0, 0, 0, 0, 2, 0, 0, 5);
    expq.push_back(page_exp(0));
    start(0);
    run_chunks(0);
    @(negedge clk);
    chk("R4 uncorr flag", int'(status), 3);
    set_chunks(0, 0, 0, 0, 0, 0, 0, 10, -1);
    expq.push_back(page_exp(0));
    start(0);
    run_chunks(1);
    @(negedge clk);
    chk("R4 over limit", int'(status), 3);

    // R6 bypass: results ignored, one chunk per cycle
    dec_en = 0;
    expq.push_back(2'b00);
    start(0);
    cdone = 1; unc = 1; ecnt = 4'd15;
    for (int k = 0; k < N; k++) begin
      chk("R6 idx per cycle", int'(idx), k);
      chk("R6 no dec strobe", int'(dec_a), 0);
      @(negedge clk);
    end
    chk("R6 done after N", int'(done), 1);
    chk("R6 status clean", int'(status), 0);
    cdone = 0; unc = 0; ecnt = '0;
    @(negedge clk);
    dec_en = 1;

    // R9 priority: both starts together
    prog_start = 1; read_start = 1;
    @(negedge clk);
    prog_start = 0; read_start = 0;
    chk("R9 program wins", int'(enc_a), 1);
    expq.push_back(2'b00);
    run_chunks(0);
    @(negedge clk);

    // R8 continuous read, two pages then deselect
    cont = 1; sel = 1;
    set_chunks(0, 2, 0, 0, 0, 0, 0, 0, -1);
    expq.push_back(page_exp(0));
    start(0);
    chk("R8 cr_active", int'(cr_a), 1);
    run_chunks(0);
    set_chunks(0, 0, 0, 0, 0, 0, 0, 0, 6);
    expq.push_back(page_exp(0));
    @(negedge clk);
    chk("R8 next page auto", int'(cr_a), 1);
    chk("R8 next page status clear", int'(status), 0);
    sel = 0;
    run_chunks(1);
    @(negedge clk);
    chk("R8 deselect idle", int'(busy), 0);
    chk("R8 last status", int'(status), 3);
    cont = 0;

    repeat (3) @(negedge clk);
    chk("R5 all pages seen", expq.size(), 0);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule